// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block turns six asynchronous interrupt pins into clean, single-cycle interrupt requests. Each pin first passes through a two-flop synchroniser. It is then sampled by a strobe that fires once every four system clocks. A new level counts as real only after three strobes in a row agree on it. Short glitches are therefore dropped, and a level that stays put long enough always gets through.

Each input has a 2-bit mode field that picks which changes of the filtered level raise a request: none, rising only, falling only, or both. A request is a one-cycle pulse on that input's output bit, issued together with the change of the filtered level. During reset the filtered level copies the synchronised pin, so releasing reset never reports an edge. One free-running 2-bit counter produces the sample strobe for all inputs.

Top module: `ext_irq_filter`

## Requirements
- R1: While reset is asserted the filtered level of every input tracks the synchronised pin. With the pins held steady through reset and afterwards, no request is raised after reset is released.
- R2: With mode 2'b01 (rising only), a low-to-high pin change produces exactly one request pulse. The pulse is first seen 11 to 14 clock cycles after the pin changes.
- R3: With mode 2'b10 (falling only), a high-to-low pin change produces exactly one request pulse within the same 11 to 14 cycle window.
- R4: With mode 2'b11 (both), every settled change in either direction produces exactly one request pulse.
- R5: With mode 2'b00 (disabled), pin changes raise no request. The filtered level still follows the pin, so after the mode is set to 2'b11 the next change raises one request.
- R6: An input in rising-only mode raises no request on a falling change, and an input in falling-only mode raises no request on a rising change.
- R7: The filter only updates at a strobe, and strobes are four cycles apart. A pin pulse of 8 clock cycles or fewer never yields a request.
- R8: A pin level held for 12 clock cycles or more is always accepted. A 12-cycle high pulse under mode 2'b11 yields two requests.
- R9: Every request is high for exactly one clock cycle.
- R10: Inputs are independent. Activity on one pin never raises a request on another bit. Bit n of the mode bus field [2n+1:2n] belongs to input n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | N_IN (6) | Raw asynchronous interrupt pins |
| mode_i | input | 2*N_IN (12) | Edge mode per input: 00 off, 01 rising, 10 falling, 11 both |
| irq_o | output | N_IN (6) | One-cycle interrupt request per input |

## Verification
A pin change reaches the filter after two synchroniser cycles. The first sample of the new level happens within the next four cycles, because the strobe phase is free-running. The third agreeing sample, and with it the request, follows eight cycles later, so a request shows up 11 to 14 cycles after the pin moves. The bench drives pins on the falling clock edge and counts requests at each following falling edge for at least 30 cycles. It checks the pulse count, whether the first pulse falls inside the window, and that no request stays high on two consecutive samples. Pulse tests hold the pin for a counted number of cycles and keep counting after it returns, so a late acceptance is not missed.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Does a level change old_lvl -> new_lvl match the selected mode?
  function automatic logic edge_hit(input logic [1:0] mode,
                                    input logic old_lvl,
                                    input logic new_lvl);
    logic want_rise;
    logic want_fall;
    want_rise = (mode == EDGE_RISE) || (mode == EDGE_ANY);
    want_fall = (mode == EDGE_FALL) || (mode == EDGE_ANY);
    return (old_lvl != new_lvl) && (new_lvl ? want_rise : want_fall);
  endfunction

  // A new level is accepted when the stored samples and the current one
  // all agree and differ from the present filtered level.
  function automatic logic settle_ok(input logic [7:0] hist,
                                     input int unsigned hist_w,
                                     input logic cur,
                                     input logic lvl);
    logic same;
    same = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(hist_w) && hist[i] != cur) same = 1'b0;
    end
    return same && (cur != lvl);
  endfunction

endpackage

// File: rtl/irqf_strobe.sv
module irqf_strobe #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + DIV_W'(1);
  end

  assign stb_o = &cnt_q;
endmodule

// File: rtl/irqf_filter.sv
module irqf_filter
  import irqf_pkg::*;
#(
  parameter int SAMPLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic pin_i,
  output logic lvl_o,
  output logic chg_o
);
  localparam int HW = SAMPLES - 1;

  logic          meta_q;
  logic          sync_q;
  logic [HW-1:0] hist_q;
  logic          lvl_q;
  logic [7:0]    hist_ext;

  always_ff @(posedge clk) begin
    meta_q <= pin_i;
    sync_q <= meta_q;
  end

  assign hist_ext = 8'(hist_q);
  assign chg_o    = stb_i && settle_ok(hist_ext, HW, sync_q, lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= {HW{sync_q}};
      lvl_q  <= sync_q;
    end else begin
      if (stb_i) hist_q <= HW'({hist_q, sync_q});
      if (chg_o) lvl_q  <= sync_q;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irqf_edge.sv
module irqf_edge
  import irqf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       chg_i,
  input  logic       lvl_i,
  output logic       irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= chg_i && edge_hit(mode_i, lvl_i, !lvl_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter #(
  parameter int N_IN    = 6,
  parameter int DIV_W   = 2,
  parameter int SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pin_i,
  input  logic [2*N_IN-1:0] mode_i,
  output logic [N_IN-1:0]   irq_o
);
  logic            smp_stb;
  logic [N_IN-1:0] flt_lvl;
  logic [N_IN-1:0] flt_chg;

  irqf_strobe #(.DIV_W(DIV_W)) u_stb (
    .clk  (clk),
    .rst_n(rst_n),
    .stb_o(smp_stb)
  );

  for (genvar ch = 0; ch < N_IN; ch++) begin : g_ch
    irqf_filter #(.SAMPLES(SAMPLES)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .stb_i(smp_stb),
      .pin_i(pin_i[ch]),
      .lvl_o(flt_lvl[ch]),
      .chg_o(flt_chg[ch])
    );

    irqf_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .mode_i(mode_i[2*ch +: 2]),
      .chg_i (flt_chg[ch]),
      .lvl_i (flt_lvl[ch]),
      .irq_o (irq_o[ch])
    );
  end
endmodule

// File: rtl/ext_irq_filter_chk.sv
module ext_irq_filter_chk #(
  parameter int N_IN = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*N_IN-1:0] mode_i,
  input logic [N_IN-1:0]   irq_o,
  input logic              smp_stb,
  input logic [N_IN-1:0]   flt_lvl,
  input logic [N_IN-1:0]   flt_chg
);
  // R9
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & $past(irq_o)) == '0);

  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);

  for (genvar c = 0; c < N_IN; c++) begin : g_c
    // R7
    flt_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && flt_lvl[c] != $past(flt_lvl[c])) |-> $past(smp_stb));

    // R5
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> ($past(mode_i[2*c +: 2]) != 2'b00));

    // R2
    rise_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] && flt_lvl[c]) |-> $past(mode_i[2*c]));

    // R3
    fall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] && !flt_lvl[c]) |-> $past(mode_i[2*c+1]));

    // R4
    irq_after_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> $past(flt_chg[c]));
  end
endmodule

bind ext_irq_filter ext_irq_filter_chk #(.N_IN(N_IN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_i (mode_i),
  .irq_o  (irq_o),
  .smp_stb(smp_stb),
  .flt_lvl(flt_lvl),
  .flt_chg(flt_chg)
);

// File: tb/ext_irq_filter_test.sv
module ext_irq_filter_test;
  localparam int N = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pin = 6'b101010;
  logic [2*N-1:0] mode = '1;
  logic [N-1:0]   irq;

  int nchk = 0;
  int nfail = 0;
  int wide = 0;
  int pcnt [N];
  int pfirst [N];
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_filter uut (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin),
    .mode_i(mode),
    .irq_o (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int c = 0; c < N; c++) begin
      pcnt[c] = 0;
      pfirst[c] = -1;
    end
  endtask

  // Counts request pulses over n falling edges; offsets continue from 'base'.
  task automatic watch(input int n, input int base);
    logic [N-1:0] prev;
    prev = irq;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
        if (irq[c]) begin
          pcnt[c]++;
          if (pfirst[c] < 0) pfirst[c] = base + k;
          if (prev[c]) wide++;
        end
      end
      prev = irq;
    end
  endtask

  task automatic set_mode(input int c, input logic [1:0] m);
    mode[2*c +: 2] = m;
  endtask

  task automatic one_edge(input int c, input logic val, input string req, input int exp_n);
    clear_counts();
    pin[c] = val;
    watch(30, 0);
    chk(pcnt[c] == exp_n, req, pcnt[c], exp_n);
    if (exp_n == 1) begin
      chk(pfirst[c] >= 11 && pfirst[c] <= 14, {req, " latency"}, pfirst[c], 11);
    end
  endtask

  task automatic t_reset();
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    clear_counts();
    watch(30, 0);
    for (int c = 0; c < N; c++) chk(pcnt[c] == 0, "R1 no request after reset", pcnt[c], 0);
  endtask

  task automatic t_rise();
    set_mode(0, 2'b01);
    one_edge(0, 1'b1, "R2 rising edge", 1);
  endtask

  task automatic t_fall();
    set_mode(1, 2'b10);
    one_edge(1, 1'b0, "R3 falling edge", 1);
  endtask

  task automatic t_both();
    set_mode(2, 2'b11);
    one_edge(2, 1'b1, "R4 both, rise", 1);
    one_edge(2, 1'b0, "R4 both, fall", 1);
  endtask

  task automatic t_off();
    set_mode(3, 2'b00);
    one_edge(3, 1'b0, "R5 disabled input", 0);
    set_mode(3, 2'b11);
    one_edge(3, 1'b1, "R5 level tracked while disabled", 1);
  endtask

  task automatic t_wrong_dir();
    one_edge(0, 1'b0, "R6 rising mode ignores fall", 0);
    one_edge(1, 1'b1, "R6 falling mode ignores rise", 0);
  endtask

  task automatic t_short();
    set_mode(4, 2'b11);
    foreach (pw_list[i]) begin
      clear_counts();
      pin[4] = 1'b1;
      watch(pw_list[i], 0);
      pin[4] = 1'b0;
      watch(30, pw_list[i]);
      chk(pcnt[4] == 0, "R7 short pulse rejected", pcnt[4], 0);
    end
  endtask
  int pw_list [3] = '{1, 4, 8};

  task automatic t_long();
    clear_counts();
    pin[4] = 1'b1;
    watch(12, 0);
    pin[4] = 1'b0;
    watch(30, 12);
    chk(pcnt[4] == 2, "R8 12-cycle pulse accepted", pcnt[4], 2);
    chk(pfirst[4] >= 11 && pfirst[4] <= 14, "R8 first edge latency", pfirst[4], 11);
  endtask

  task automatic t_indep();
    mode = '1;
    clear_counts();
    pin[0] = 1'b1;
    pin[5] = 1'b0;
    watch(30, 0);
    chk(pcnt[0] == 1, "R10 input 0 request", pcnt[0], 1);
    chk(pcnt[5] == 1, "R10 input 5 request", pcnt[5], 1);
    for (int c = 1; c < 5; c++) chk(pcnt[c] == 0, "R10 quiet inputs", pcnt[c], 0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_wrong_dir();
    t_short();
    t_long();
    t_indep();
    chk(wide == 0, "R9 single-cycle pulses", wide, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule